// File: doc/BRIEF.md
# DShot Multi-Channel Frame Transmitter

This block drives up to four motor-controller lines with DShot frames. A host writes a 16-bit requested throttle into a per-channel register, sets a mask of active channels and the number of clocks that one bit slot lasts, and then pulses a trigger. On that trigger every active channel latches its encoded frame and all lines start together.

Each requested value is limited to 11 bits. A telemetry-request flag is added for the command range, and a 4-bit nibble checksum is appended. The 16 frame bits go out most significant bit first. Each bit sits in a fixed-length slot whose high time marks a 0 or a 1. The block derives both high times from the slot length itself.

Every transmission is 18 slots long: a silent leading slot, the 16 data slots and a silent trailing slot. The lines therefore always come back to idle low. `busy` covers the whole transmission, and `done` marks its completion for one clock.

Top module: `dshot_tx`

## Requirements
- R1: A requested value above 2047 is encoded as 2047. Values up to 2047 are encoded unchanged.
- R2: The encoded value occupies frame bits 15..5. Frame bit 4 is the telemetry flag, set exactly when the encoded value is in the range 1 to 47 and clear otherwise, including for 0.
- R3: Frame bits 3..0 equal the XOR of frame nibbles 15..12, 11..8 and 7..4, taken after the flag is placed.
- R4: Frame bits go out most significant first, one per slot. Each slot lasts exactly `bit_div` clocks, with `bit_div` sampled at the accepted trigger.
- R5: In a data slot the line is high from the slot's first clock for T clocks and low for the rest. T is (div*36+50)/100 for a 0 bit and (div*74+50)/100 for a 1 bit, using integer division.
- R6: The first and the last of the 18 slots have no high time. The lines are low whenever `busy` is low.
- R7: All enabled channels begin their slots on the same clock, one clock after the edge that accepts the trigger.
- R8: A trigger seen while `busy` is high has no effect. The transmission in progress ends at its original time and no new one starts.
- R9: Each channel's frame is taken from its register at the accepted trigger. A write made during a transmission appears only in the next one.
- R10: `busy` rises one clock after an accepted trigger. `done` is high for exactly one clock, 18*div clocks after `busy` rises, and `busy` falls in that same clock.
- R11: A channel whose bit in `en_mask` (bit i is channel i) is 0 at the accepted trigger stays low for the whole transmission.
- R12: After reset the lines, `busy` and `done` are low and every throttle register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Throttle register write strobe |
| wr_ch | input | 2 | Channel selected for the write |
| wr_data | input | 16 | Requested throttle value |
| en_mask | input | 4 | Channel enable mask, sampled at trigger |
| bit_div | input | 16 | Clocks per bit slot, at least 2, sampled at trigger |
| trig | input | 1 | Starts one synchronized transmission when idle |
| busy | output | 1 | Transmission in progress |
| done | output | 1 | One-clock pulse at the end of a transmission |
| motor_out | output | 4 | Serial DShot lines, one per channel |

## Verification
The hardest conditions to reach from the ports are a trigger and a register write that arrive in the middle of a transmission. Each must leave the current waveform and its end time untouched and take effect only later. The stimulus reaches this by asserting `trig` and writing channel 0 partway through a frame while every line is decoded clock by clock. The following frame is then decoded to confirm that the new value, clamped, appears only there.

// File: rtl/dshot_tx_pkg.sv
// Package: shared constants and frame assembly for the DShot transmitter.
// Assumes 16-bit frames built from an 11-bit value, a flag and a 4-bit checksum.
package dshot_tx_pkg;
    localparam int FRAME_W   = 16;
    localparam int VAL_W     = 11;
    localparam int NUM_SLOTS = 18;
    localparam int MAX_VAL   = 2047;
    localparam int CMD_LIMIT = 48;
    localparam int PCT_ZERO  = 36;
    localparam int PCT_ONE   = 74;

    // Assemble value and flag into a frame and append the nibble checksum.
    function automatic logic [FRAME_W-1:0] assemble(input logic [VAL_W-1:0] val,
                                                    input logic flag);
        logic [FRAME_W-1:0] f;
        f       = {val, flag, 4'b0000};
        f[3:0]  = f[15:12] ^ f[11:8] ^ f[7:4];
        return f;
    endfunction
endpackage

// File: rtl/dshot_tx_encoder.sv
// Module: combinational frame encoder.
// Clamps the request, sets the command flag and builds the checksummed frame.
// Assumes IN_W is at least 11 bits.
module dshot_tx_encoder
    import dshot_tx_pkg::*;
#(
    parameter int IN_W = 16
) (
    input  logic [IN_W-1:0]    req,
    output logic [FRAME_W-1:0] frame
);
    logic [VAL_W-1:0] val;
    logic             flag;

    // Clamp the request and decide whether it falls in the command range.
    always_comb begin
        if (req > IN_W'(MAX_VAL)) val = VAL_W'(MAX_VAL);
        else                      val = req[VAL_W-1:0];
        flag  = (val != '0) && (val < VAL_W'(CMD_LIMIT));
        frame = assemble(val, flag);
    end
endmodule

// File: rtl/dshot_tx_timebase.sv
// Module: shared slot timebase.
// Counts clocks within a slot and slots within a transmission, and latches the
// divisor and both duty thresholds when a start is accepted.
// Assumes div_in is at least 2; a value of 0 is treated as 1.
module dshot_tx_timebase
    import dshot_tx_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIV_W-1:0]  div_in,
    output logic [DIV_W-1:0]  div_q,
    output logic [DIV_W-1:0]  phase,
    output logic [SLOT_W-1:0] slot,
    output logic [DIV_W-1:0]  th0,
    output logic [DIV_W-1:0]  th1,
    output logic              slot_last,
    output logic              busy,
    output logic              done
);
    localparam int PROD_W = DIV_W + 8;

    logic [DIV_W-1:0]  div_eff;
    logic [PROD_W-1:0] p0, p1;

    // Round both high times to the nearest clock from the requested divisor.
    always_comb begin
        div_eff = (div_in == '0) ? DIV_W'(1) : div_in;
        p0 = (PROD_W'(div_eff) * PROD_W'(PCT_ZERO) + PROD_W'(50)) / PROD_W'(100);
        p1 = (PROD_W'(div_eff) * PROD_W'(PCT_ONE)  + PROD_W'(50)) / PROD_W'(100);
    end

    assign slot_last = busy && (phase == div_q - DIV_W'(1));

    // Advance phase and slot, and raise done after the final slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            phase <= '0;
            slot  <= '0;
            div_q <= DIV_W'(1);
            th0   <= '0;
            th1   <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy  <= 1'b1;
                phase <= '0;
                slot  <= '0;
                div_q <= div_eff;
                th0   <= p0[DIV_W-1:0];
                th1   <= p1[DIV_W-1:0];
            end else if (busy) begin
                if (slot_last) begin
                    phase <= '0;
                    if (slot == SLOT_W'(NUM_SLOTS - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                        slot <= '0;
                    end else begin
                        slot <= slot + SLOT_W'(1);
                    end
                end else begin
                    phase <= phase + DIV_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/dshot_tx_lane.sv
// Module: one output lane.
// Holds the frame latched at start, shifts it at the end of each data slot and
// drives the line high for the bit's threshold in each data slot.
// Assumes the timebase supplies phase, slot and thresholds.
module dshot_tx_lane
    import dshot_tx_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int SLOT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               en_in,
    input  logic               busy,
    input  logic               slot_last,
    input  logic [SLOT_W-1:0]  slot,
    input  logic [DIV_W-1:0]   phase,
    input  logic [DIV_W-1:0]   th0,
    input  logic [DIV_W-1:0]   th1,
    output logic               line
);
    logic [FRAME_W-1:0] sh_q;
    logic               en_q;
    logic               data_slot;

    assign data_slot = busy && (slot >= SLOT_W'(1)) && (slot <= SLOT_W'(FRAME_W));

    // Latch frame and enable at start; shift after each data slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            en_q <= 1'b0;
        end else if (load) begin
            sh_q <= frame_in;
            en_q <= en_in;
        end else if (data_slot && slot_last) begin
            sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
        end
    end

    // Line is high at the start of a data slot until the bit's threshold.
    always_comb begin
        line = en_q && data_slot && (phase < (sh_q[FRAME_W-1] ? th1 : th0));
    end
endmodule

// File: rtl/dshot_tx.sv
// Module: multi-channel DShot frame transmitter (top).
// Holds per-channel throttle registers and starts one aligned transmission on
// all enabled lanes per accepted trigger. Assumes one clock domain and a
// synchronous active-low reset.
module dshot_tx
    import dshot_tx_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int THR_W = 16,
    parameter int DIV_W = 16,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [THR_W-1:0] wr_data,
    input  logic [NCH-1:0]   en_mask,
    input  logic [DIV_W-1:0] bit_div,
    input  logic             trig,
    output logic             busy,
    output logic             done,
    output logic [NCH-1:0]   motor_out
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);

    logic [THR_W-1:0]  thr_q [NCH];
    logic              start;
    logic [DIV_W-1:0]  div_q, phase, th0, th1;
    logic [SLOT_W-1:0] slot;
    logic              slot_last;

    assign start = trig && !busy;

    // Store host writes into the selected throttle register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) thr_q[i] <= '0;
        end else if (wr_en) begin
            thr_q[wr_ch] <= wr_data;
        end
    end

    dshot_tx_timebase #(.DIV_W(DIV_W), .SLOT_W(SLOT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .start(start), .div_in(bit_div),
        .div_q(div_q), .phase(phase), .slot(slot), .th0(th0), .th1(th1),
        .slot_last(slot_last), .busy(busy), .done(done)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        logic [FRAME_W-1:0] frame;

        dshot_tx_encoder #(.IN_W(THR_W)) u_enc (
            .req(thr_q[c]), .frame(frame)
        );

        dshot_tx_lane #(.DIV_W(DIV_W), .SLOT_W(SLOT_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .load(start), .frame_in(frame),
            .en_in(en_mask[c]), .busy(busy), .slot_last(slot_last),
            .slot(slot), .phase(phase), .th0(th0), .th1(th1),
            .line(motor_out[c])
        );
    end
endmodule

// File: rtl/dshot_tx_checker.sv
// Module: protocol checker bound to dshot_tx.
// Tracks its own clock count since the accepted trigger and its own slot phase,
// then checks framing, alignment and completion timing against them.
module dshot_tx_checker #(
    parameter int NCH   = 4,
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig,
    input logic             busy,
    input logic             done,
    input logic [NCH-1:0]   motor_out,
    input logic [DIV_W-1:0] div_q
);
    logic [31:0]      ck_n;
    logic [DIV_W-1:0] ph;

    // Count clocks and slot phase from the accepted trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_n <= '0;
            ph   <= '0;
        end else if (trig && !busy) begin
            ck_n <= '0;
            ph   <= '0;
        end else if (busy) begin
            ck_n <= ck_n + 32'd1;
            ph   <= (ph == div_q - DIV_W'(1)) ? '0 : ph + DIV_W'(1);
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R10
    AST_DONE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ck_n == 32'(div_q) * 32'd18));                           // R10
    AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);                                             // R10
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (motor_out == '0));                                      // R6
    AST_LEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ck_n < 32'(div_q)) |-> (motor_out == '0));                // R6
    AST_TRAIL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ck_n >= 32'(div_q) * 32'd17) |-> (motor_out == '0));      // R6
    AST_EDGE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (|(motor_out & ~$past(motor_out))) |-> (ph == '0));                // R7
endmodule

bind dshot_tx dshot_tx_checker #(.NCH(NCH), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .trig(trig), .busy(busy), .done(done),
    .motor_out(motor_out), .div_q(div_q)
);

// File: tb/sim_dshot_tx.sv
module sim_dshot_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_ch = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  en_mask = '0;
    logic [15:0] bit_div = 16'd10;
    logic        trig = 1'b0;
    logic        busy, done;
    logic [3:0]  motor_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dshot_tx u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_data(wr_data), .en_mask(en_mask), .bit_div(bit_div),
        .trig(trig), .busy(busy), .done(done), .motor_out(motor_out)
    );

    // Stimulus vectors: requested value and the expected frame (R1, R2, R3).
    localparam logic [15:0] VT [0:7] = '{16'd0, 16'd1, 16'd47, 16'd48,
                                         16'd1000, 16'd2047, 16'd3000, 16'd1046};
    localparam logic [15:0] VE [0:7] = '{16'h0000, 16'h0033, 16'h05FA, 16'h0606,
                                         16'h7D0A, 16'hFFEE, 16'hFFEE, 16'h82C6};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_ch(input int ch, input logic [15:0] v);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Run one transmission, compare every clock of every line, then check done.
    task automatic run_frame(input int div, input logic [3:0] mask,
                             input logic [15:0] e0, input logic [15:0] e1,
                             input logic [15:0] e2, input logic [15:0] e3,
                             input bit poke, input string tag);
        logic [15:0] ex [4];
        int bad [4];
        int bsy_bad;
        int t0, t1;
        ex[0] = e0; ex[1] = e1; ex[2] = e2; ex[3] = e3;
        t0 = (div * 36 + 50) / 100;
        t1 = (div * 74 + 50) / 100;
        for (int c = 0; c < 4; c++) bad[c] = 0;
        bsy_bad = 0;
        bit_div = 16'(div); en_mask = mask; trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        for (int k = 0; k < 18 * div; k++) begin
            int s, ph;
            s = k / div; ph = k % div;
            if (poke && k == 3 * div) begin wr_en = 1'b1; wr_ch = 2'd0; wr_data = 16'hFFFF; end
            if (poke && k == 3 * div + 1) wr_en = 1'b0;
            if (poke && k == 5 * div) trig = 1'b1;
            if (poke && k == 5 * div + 1) trig = 1'b0;
            if (!busy || done) bsy_bad++;
            for (int c = 0; c < 4; c++) begin
                int hi;
                if (s == 0 || s == 17 || !mask[c]) hi = 0;
                else hi = ex[c][16 - s] ? t1 : t0;
                if (motor_out[c] !== (ph < hi)) bad[c]++;
            end
            @(negedge clk);
        end
        for (int c = 0; c < 4; c++)
            check(bad[c] == 0, $sformatf("%s waveform ch%0d mismatched clocks", tag, c), bad[c], 0);
        check(bsy_bad == 0, $sformatf("%s R10 busy during frame, bad clocks", tag), bsy_bad, 0);
        check(done === 1'b1 && busy === 1'b0, $sformatf("%s R10 done/busy at end", tag),
              {done, busy}, 2'b10);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, $sformatf("%s R10 done one clock", tag),
              {done, busy}, 2'b00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state at the ports.
        check(motor_out === 4'b0 && busy === 1'b0 && done === 1'b0, "R12 reset outputs",
              {busy, done, motor_out}, 0);
        // R12: throttle registers start at zero, so every lane sends the zero frame.
        run_frame(10, 4'hF, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, "R12");

        // Table walk: two frames of four channels (R1 R2 R3 R4 R5 R6 R7).
        for (int f = 0; f < 2; f++) begin
            for (int c = 0; c < 4; c++) write_ch(c, VT[f * 4 + c]);
            run_frame(f == 0 ? 10 : 7, 4'hF, VE[f * 4], VE[f * 4 + 1], VE[f * 4 + 2],
                      VE[f * 4 + 3], 1'b0, "R1/R2/R3/R4/R5/R6/R7");
        end

        // R11: channels 1 and 3 masked off; odd divisor for R5 rounding.
        run_frame(13, 4'b0101, VE[4], VE[5], VE[6], VE[7], 1'b0, "R11/R5");

        // R8 and R9: trigger and write during a frame leave it unchanged.
        run_frame(8, 4'hF, VE[4], VE[5], VE[6], VE[7], 1'b1, "R8/R9");
        begin
            int stray;
            stray = 0;
            for (int k = 0; k < 4; k++) begin
                if (busy !== 1'b0 || motor_out !== 4'b0) stray++;
                @(negedge clk);
            end
            check(stray == 0, "R8 no restart after ignored trigger", stray, 0);
        end
        // R9 and R1: the mid-frame write of 0xFFFF shows up clamped in the next frame.
        run_frame(9, 4'hF, 16'hFFEE, VE[5], VE[6], VE[7], 1'b0, "R9/R1");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule